// File: doc/BRIEF.md
# Display Command Read Engine (four-wire serial link)

This block runs register reads against a small display controller attached over a four-wire serial link that has a separate data/command select line. A caller presents an 8-bit command code and a byte count, then pulses `start`. If the request is legal, the engine selects the device and drives the select line to "command". It shifts the code out MSB first, then clocks in the requested response bytes on `miso`. It returns them on `rdata` together with a one-cycle `done` strobe. An illegal request is answered at once with `done` and `rejected`, and the link is not touched.

Two reads, display identification (0x04) and display status (0x09), are preceded by one dummy clock on the wire. For these the engine clocks one extra byte and shifts the whole received stream left by one bit, so the caller sees clean bytes. After a power-mode read (0x0A), the engine also reports whether the returned byte says the panel is awake and showing normal output. Reads run at a slow serial rate derived at elaboration time from the system clock and the link's rated maximum. A combinational output tells at any time whether the code on `cmd` is one the engine will read.

Top module: `dcs_read_engine`

## Requirements
- R1: `readable` is 1 exactly for the codes 0x04, 0x06, 0x07, 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0D, 0x0E, 0x0F, 0x2E, 0x3E, 0x45, 0x52, 0x54, 0x56, 0x5F, 0xA1 and 0xA8 on `cmd`, and 0 for every other code.
- R2: A `start` is rejected if any of these holds: the code is not readable, `len` is 0, `len` exceeds MAX_BYTES, or the code is 0x04 or 0x09 with `len` other than 3 or 4. On a rejected start, `done` and `rejected` are 1 in the next cycle and `cs_n` never goes low.
- R3: An accepted read holds `cs_n` low from the first command bit to the last response bit. `dc` is low whenever `cs_n` is low and high otherwise. `sclk` rests low. The command is shifted out MSB first on `mosi` during the first 8 SCLK periods, and `mosi` changes only while `sclk` is low.
- R4: After the command, `len` bytes are taken from `miso` on rising SCLK edges, MSB first. The first byte received lands in `rdata[7:0]` and byte i lands in `rdata[8i+7:8i]`. Bytes at positions `len` and above read as zero.
- R5: For codes 0x04 and 0x09 the engine runs 8+8*(len+1) SCLK periods. Taking raw[] as the received bytes, output byte i equals ((raw[i] << 1) | (raw[i+1] >> 7)) truncated to 8 bits.
- R6: SCLK high and low phases each last HALF = ceil(SYS_HZ / (2*RATE)) system clocks, where RATE = min(READ_CAP_HZ, LINK_MAX_HZ/2).
- R7: After an accepted 0x0A read, `display_on` is 1 exactly when (byte0 & 0x7C) == 0x1C. After any other completed or rejected request it is 0.
- R8: After reset, `cs_n`=1, `sclk`=0, `busy`=0 and `done`=0. `busy` is high from the cycle after an accepted start until `done`. `done` lasts one cycle, in the same cycle `cs_n` returns high.
- R9: `start` while `busy` is ignored: the running read finishes with its own command and data, and no further read follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a read (one cycle) |
| cmd | input | 8 | Command code |
| len | input | LW | Response bytes requested |
| readable | output | 1 | `cmd` is in the readable set |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle completion strobe |
| rejected | output | 1 | Last request was refused |
| display_on | output | 1 | Power-mode result says panel is on |
| rdata | output | 8*MAX_BYTES | Received bytes, first byte lowest |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Device select, active low |
| dc | output | 1 | Data/command select, low for command |
| mosi | output | 1 | Serial data to device |
| miso | input | 1 | Serial data from device |

## Verification
The bench builds the engine with SYS_HZ=16 MHz, LINK_MAX_HZ=3 MHz and MAX_BYTES=4. With these values the rate comes from half the link maximum (1.5 MHz) rather than the 2 MHz cap. The division does not come out even, so the rounding up to HALF=6 is visible in the measured SCLK phases. MAX_BYTES=4 is the smallest size that admits both legal lengths of the dummy-clock reads. It also lets a length of 5 hit the upper-bound rejection, and short-period transactions keep every read of the five-byte raw buffer within a few hundred cycles.

// File: rtl/dcs_rd_pkg.sv
`timescale 1ns/1ps
package dcs_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } rd_state_e;

  localparam logic [7:0] CODE_ID     = 8'h04;
  localparam logic [7:0] CODE_STATUS = 8'h09;
  localparam logic [7:0] CODE_PWR    = 8'h0A;

  // power-mode decode: keep bits 2..6, expect bits 2,3,4 set
  localparam logic [7:0] PWR_KEEP = 8'h7C;
  localparam logic [7:0] PWR_ON   = 8'h1C;

  function automatic int calc_half(input int sys_hz, input int link_hz,
                                   input int cap_hz);
    int rate;
    rate = ((link_hz / 2) < cap_hz) ? (link_hz / 2) : cap_hz;
    return (sys_hz + 2 * rate - 1) / (2 * rate);
  endfunction

endpackage

// File: rtl/dcs_cmd_classifier.sv
`timescale 1ns/1ps
module dcs_cmd_classifier
  import dcs_rd_pkg::*;
(
  input  logic [7:0] code,
  output logic       is_readable,
  output logic       lead_dummy
);

  always_comb begin
    unique case (code)
      8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D,
      8'h0E, 8'h0F, 8'h2E, 8'h3E, 8'h45, 8'h52, 8'h54, 8'h56, 8'h5F,
      8'hA1, 8'hA8: is_readable = 1'b1;
      default:      is_readable = 1'b0;
    endcase
  end

  assign lead_dummy = (code == CODE_ID) || (code == CODE_STATUS);

endmodule

// File: rtl/dcs_tick_gen.sv
`timescale 1ns/1ps
module dcs_tick_gen #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dcs_realign.sv
`timescale 1ns/1ps
module dcs_realign #(
  parameter int MAX_BYTES = 4,
  parameter int LW = 3,
  parameter int NW = 3
) (
  input  logic [8*(MAX_BYTES+1)-1:0] raw,
  input  logic [NW-1:0]              nraw,
  input  logic [LW-1:0]              nout,
  input  logic                       drop_lead,
  output logic [8*MAX_BYTES-1:0]     bytes_out
);

  localparam int NRAW_MAX = MAX_BYTES + 1;
  localparam int RAW_W    = 8 * NRAW_MAX;

  logic [RAW_W-1:0] top_aligned;
  logic [RAW_W-1:0] bit_aligned;

  always_comb begin
    // move the first received byte to the top of the vector
    top_aligned = raw << (8 * (NRAW_MAX - int'(nraw)));
    bit_aligned = drop_lead ? (top_aligned << 1) : top_aligned;
  end

  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_lane
    assign bytes_out[8*i +: 8] = (i < int'(nout)) ?
                                 bit_aligned[RAW_W-1-8*i -: 8] : 8'h00;
  end

endmodule

// File: rtl/dcs_read_engine.sv
`timescale 1ns/1ps
module dcs_read_engine
  import dcs_rd_pkg::*;
#(
  parameter int SYS_HZ      = 250_000_000,
  parameter int LINK_MAX_HZ = 20_000_000,
  parameter int READ_CAP_HZ = 2_000_000,
  parameter int MAX_BYTES   = 4,
  localparam int LW         = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [7:0]             cmd,
  input  logic [LW-1:0]          len,
  output logic                   readable,
  output logic                   busy,
  output logic                   done,
  output logic                   rejected,
  output logic                   display_on,
  output logic [8*MAX_BYTES-1:0] rdata,
  output logic                   sclk,
  output logic                   cs_n,
  output logic                   dc,
  output logic                   mosi,
  input  logic                   miso
);

  localparam int HALF     = calc_half(SYS_HZ, LINK_MAX_HZ, READ_CAP_HZ);
  localparam int NRAW_MAX = MAX_BYTES + 1;
  localparam int RAW_W    = 8 * NRAW_MAX;
  localparam int NW       = $clog2(NRAW_MAX + 1);
  localparam int TOT_MAX  = 8 + 8 * NRAW_MAX;
  localparam int BW       = $clog2(TOT_MAX + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  // request classification
  logic lead_dummy, len_ok, accept;
  logic [NW-1:0] nraw_in;

  dcs_cmd_classifier u_cls (
    .code        (cmd),
    .is_readable (readable),
    .lead_dummy  (lead_dummy)
  );

  always_comb begin
    len_ok = (len != '0) && (int'(len) <= MAX_BYTES);
    if (lead_dummy) len_ok = len_ok && ((len == LW'(3)) || (len == LW'(4)));
    accept  = readable && len_ok;
    nraw_in = NW'(len) + NW'(lead_dummy);
  end

  // state
  rd_state_e        state_q, state_d;
  logic [7:0]       csh_q, csh_d;
  logic [BW-1:0]    bit_q, bit_d, tot_q, tot_d;
  logic [RAW_W-1:0] raw_q, raw_d;
  logic [LW-1:0]    len_q, len_d;
  logic [NW-1:0]    nraw_q, nraw_d;
  logic             dum_q, dum_d, pwr_q, pwr_d;
  logic             sclk_q, sclk_d, csn_q, csn_d;
  logic             done_q, done_d, rej_q, rej_d, on_q, on_d;
  logic [8*MAX_BYTES-1:0] rdata_q, rdata_d, aligned;
  logic             tick;

  dcs_tick_gen #(.HALF(HALF)) u_tick (
    .clk   (clk),
    .rst_n (rst_i_n),
    .run   (state_q == ST_XFER),
    .tick  (tick)
  );

  dcs_realign #(.MAX_BYTES(MAX_BYTES), .LW(LW), .NW(NW)) u_align (
    .raw       (raw_q),
    .nraw      (nraw_q),
    .nout      (len_q),
    .drop_lead (dum_q),
    .bytes_out (aligned)
  );

  always_comb begin
    state_d = state_q;  csh_d = csh_q;   bit_d = bit_q;   tot_d = tot_q;
    raw_d   = raw_q;    len_d = len_q;   nraw_d = nraw_q; dum_d = dum_q;
    pwr_d   = pwr_q;    sclk_d = sclk_q; csn_d = csn_q;   done_d = 1'b0;
    rej_d   = rej_q;    on_d = on_q;     rdata_d = rdata_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (accept) begin
            state_d = ST_XFER;
            csn_d   = 1'b0;
            csh_d   = cmd;
            bit_d   = '0;
            tot_d   = BW'(8) + (BW'(nraw_in) << 3);
            raw_d   = '0;
            len_d   = len;
            nraw_d  = nraw_in;
            dum_d   = lead_dummy;
            pwr_d   = (cmd == CODE_PWR);
          end else begin
            done_d = 1'b1;
            rej_d  = 1'b1;
            on_d   = 1'b0;
          end
        end
      end
      ST_XFER: begin
        if (tick) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
            if (bit_q >= BW'(8)) raw_d = {raw_q[RAW_W-2:0], miso};
          end else begin
            sclk_d = 1'b0;
            if (bit_q == tot_q - BW'(1)) begin
              state_d = ST_FIN;
            end else begin
              bit_d = bit_q + BW'(1);
              csh_d = {csh_q[6:0], 1'b0};
            end
          end
        end
      end
      ST_FIN: begin
        state_d = ST_IDLE;
        csn_d   = 1'b1;
        done_d  = 1'b1;
        rej_d   = 1'b0;
        rdata_d = aligned;
        on_d    = pwr_q && ((aligned[7:0] & PWR_KEEP) == PWR_ON);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE; csh_q <= '0;  bit_q <= '0;   tot_q <= '0;
      raw_q   <= '0;      len_q <= '0;  nraw_q <= '0;  dum_q <= 1'b0;
      pwr_q   <= 1'b0;    sclk_q <= 1'b0; csn_q <= 1'b1; done_q <= 1'b0;
      rej_q   <= 1'b0;    on_q <= 1'b0; rdata_q <= '0;
    end else begin
      state_q <= state_d; csh_q <= csh_d; bit_q <= bit_d; tot_q <= tot_d;
      raw_q   <= raw_d;   len_q <= len_d; nraw_q <= nraw_d; dum_q <= dum_d;
      pwr_q   <= pwr_d;   sclk_q <= sclk_d; csn_q <= csn_d; done_q <= done_d;
      rej_q   <= rej_d;   on_q <= on_d;  rdata_q <= rdata_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign rejected   = rej_q;
  assign display_on = on_q;
  assign rdata      = rdata_q;
  assign sclk       = sclk_q;
  assign cs_n       = csn_q;
  assign dc         = csn_q;
  assign mosi       = csh_q[7];

endmodule

// File: rtl/dcs_read_engine_chk.sv
`timescale 1ns/1ps
module dcs_read_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic rejected,
  input logic display_on,
  input logic sclk,
  input logic cs_n,
  input logic dc,
  input logic mosi
);

  p_idle_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_dc_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !dc);

  p_sclk_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  p_reject_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rejected) |-> (cs_n && $past(cs_n)));

  p_on_not_rejected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    display_on |-> !rejected);

endmodule

bind dcs_read_engine dcs_read_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .rejected   (rejected),
  .display_on (display_on),
  .sclk       (sclk),
  .cs_n       (cs_n),
  .dc         (dc),
  .mosi       (mosi)
);

// File: tb/dcs_read_engine_test.sv
`timescale 1ns/1ps
module dcs_read_engine_test;

  localparam int MAXB  = 4;
  localparam int LW    = 3;
  localparam int HALF_EXP = 6; // ceil(16e6 / (2*min(2e6, 1.5e6)))

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] cmd = 8'h00;
  logic [LW-1:0] len = '0;
  logic miso = 1'b0;
  logic readable, busy, done, rejected, display_on, sclk, cs_n, dc, mosi;
  logic [8*MAXB-1:0] rdata;

  always #2 clk = ~clk;

  dcs_read_engine #(
    .SYS_HZ(16_000_000), .LINK_MAX_HZ(3_000_000),
    .READ_CAP_HZ(2_000_000), .MAX_BYTES(MAXB)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .len(len),
    .readable(readable), .busy(busy), .done(done), .rejected(rejected),
    .display_on(display_on), .rdata(rdata), .sclk(sclk), .cs_n(cs_n),
    .dc(dc), .mosi(mosi), .miso(miso)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // device model and link monitors
  logic [63:0] stream = '0;
  int sidx = 0, rise_cnt = 0, fall_cnt = 0, cs_falls = 0;
  longint cyc = 0, r1 = 0, r2 = 0, f1 = 0;
  logic [7:0] cap_cmd = 8'h00;
  bit dc_bad = 0, mode_bad = 0;
  logic prev_sclk = 1'b0, prev_mosi = 1'b0, prev_cs = 1'b1;

  always @(posedge clk) cyc++;

  always @(posedge sclk) begin
    rise_cnt++;
    if (rise_cnt <= 8) cap_cmd = {cap_cmd[6:0], mosi};
    if (rise_cnt == 1) r1 = cyc;
    if (rise_cnt == 2) r2 = cyc;
  end

  always @(negedge sclk) begin
    if (!cs_n) begin
      fall_cnt++;
      if (fall_cnt == 1) f1 = cyc;
      sidx++;
      miso = stream[63 - sidx];
    end
  end

  always @(negedge clk) begin
    if (!cs_n && dc) dc_bad = 1;
    if (!cs_n && sclk && prev_sclk && (mosi != prev_mosi)) mode_bad = 1;
    if (!cs_n && prev_cs) cs_falls++;
    prev_sclk = sclk; prev_mosi = mosi; prev_cs = cs_n;
  end

  int lat;
  bit busy_seen;

  task automatic run_read(input logic [7:0] c, input logic [LW-1:0] l,
                          input logic [63:0] s);
    stream = s; sidx = 0; miso = s[63]; rise_cnt = 0; fall_cnt = 0;
    cap_cmd = 8'h00; dc_bad = 0; mode_bad = 0; cs_falls = 0;
    @(negedge clk); start = 1'b1; cmd = c; len = l;
    @(negedge clk); start = 1'b0;
    busy_seen = busy;
    lat = 0;
    for (int k = 0; k < 20000; k++) begin
      if (done) break;
      lat++;
      @(negedge clk);
    end
  endtask

  function automatic bit is_rd(input logic [7:0] c);
    case (c)
      8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D,
      8'h0E, 8'h0F, 8'h2E, 8'h3E, 8'h45, 8'h52, 8'h54, 8'h56, 8'h5F,
      8'hA1, 8'hA8: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && dc == 1'b1, "R3 reset link idle",
        {cs_n, sclk, dc}, 3'b101);
    chk(busy == 1'b0 && done == 1'b0, "R8 reset status", {busy, done}, 2'b00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_classify;
    int bad = 0;
    for (int c = 0; c < 256; c++) begin
      cmd = 8'(c);
      #0.5;
      if (readable !== is_rd(8'(c))) begin
        bad++;
        chk(1'b0, "R1 readable set", {cmd, readable}, {cmd, is_rd(8'(c))});
      end
    end
    chk(bad == 0, "R1 readable sweep", bad, 0);
  endtask

  task automatic t_reject(input logic [7:0] c, input logic [LW-1:0] l,
                          input string why);
    run_read(c, l, 64'h0);
    chk(done && rejected && lat == 0, {"R2 reject ", why},
        {done, rejected, 8'(lat)}, {2'b11, 8'h00});
    chk(cs_falls == 0 && rise_cnt == 0 && !display_on, {"R2 link quiet ", why},
        {8'(cs_falls), 8'(rise_cnt)}, 16'h0);
    @(negedge clk);
  endtask

  task automatic t_power(input logic [7:0] b, input bit exp_on);
    run_read(8'h0A, 3'd1, {8'h00, b, 48'h0});
    chk(done && !rejected, "R8 done after read", {done, rejected}, 2'b10);
    chk(cap_cmd == 8'h0A, "R3 command shifted MSB first", cap_cmd, 8'h0A);
    chk(!dc_bad && !mode_bad, "R3 dc low and mosi timing", {dc_bad, mode_bad}, 2'b00);
    chk(rise_cnt == 16, "R4 one byte clocked", rise_cnt, 16);
    chk(rdata == {24'h0, b}, "R4 single byte placement", rdata, {24'h0, b});
    chk(display_on == exp_on, "R7 power-mode decode", display_on, exp_on);
    chk(busy_seen, "R8 busy after accept", busy_seen, 1);
    @(negedge clk);
    chk(!done && !busy, "R8 done one cycle", {done, busy}, 2'b00);
  endtask

  task automatic t_timing;
    run_read(8'h0C, 3'd1, {8'h00, 8'h66, 48'h0});
    chk(r2 - r1 == 2 * HALF_EXP, "R6 sclk period", r2 - r1, 2 * HALF_EXP);
    chk(f1 - r1 == HALF_EXP, "R6 sclk high phase", f1 - r1, HALF_EXP);
    @(negedge clk);
  endtask

  task automatic t_multi;
    run_read(8'h2E, 3'd4, {8'h00, 32'h11223344, 24'h0});
    chk(rise_cnt == 40, "R4 four bytes clocked", rise_cnt, 40);
    chk(rdata == 32'h44332211, "R4 byte order", rdata, 32'h44332211);
    chk(!display_on, "R7 not power read", display_on, 0);
    @(negedge clk);
    run_read(8'h0B, 3'd2, {8'h00, 16'hC3E7, 40'hFF_FFFF_FFFF});
    chk(rdata == 32'h0000E7C3, "R4 unused bytes zero", rdata, 32'h0000E7C3);
    @(negedge clk);
  endtask

  task automatic t_dummy(input logic [7:0] c, input logic [LW-1:0] l,
                         input logic [63:0] s);
    logic [7:0] rb [0:4];
    logic [31:0] exp;
    for (int i = 0; i < 5; i++) rb[i] = s[55 - 8*i -: 8];
    exp = '0;
    for (int i = 0; i < int'(l); i++)
      exp[8*i +: 8] = 8'((rb[i] << 1) | (rb[i+1] >> 7));
    run_read(c, l, s);
    chk(rise_cnt == 8 + 8 * (int'(l) + 1), "R5 extra byte clocked",
        rise_cnt, 8 + 8 * (int'(l) + 1));
    chk(rdata == exp, "R5 one-bit realign", rdata, exp);
    @(negedge clk);
  endtask

  task automatic t_busy_ignore;
    stream = {8'h00, 8'h5A, 48'h0}; sidx = 0; miso = stream[63];
    rise_cnt = 0; fall_cnt = 0; cap_cmd = 8'h00; cs_falls = 0;
    @(negedge clk); start = 1'b1; cmd = 8'h0B; len = 3'd1;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    start = 1'b1; cmd = 8'h2E; len = 3'd4;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      if (done) break;
      @(negedge clk);
    end
    chk(cap_cmd == 8'h0B && rise_cnt == 16, "R9 running read kept",
        {cap_cmd, 8'(rise_cnt)}, {8'h0B, 8'd16});
    chk(rdata == 32'h5A, "R9 running read data", rdata, 32'h5A);
    repeat (100) @(negedge clk);
    chk(!busy && cs_falls == 1, "R9 no second read", {busy, 8'(cs_falls)}, 9'd1);
  endtask

  initial begin
    t_reset();
    t_classify();
    t_reject(8'h2A, 3'd1, "unreadable");
    t_reject(8'h0A, 3'd0, "zero length");
    t_reject(8'h2E, 3'd5, "too long");
    t_reject(8'h04, 3'd2, "id length");
    t_reject(8'h09, 3'd1, "status length");
    t_power(8'h9C, 1'b1);
    t_power(8'h9F, 1'b1);
    t_power(8'h18, 1'b0);
    t_power(8'h1C, 1'b1);
    t_timing();
    t_multi();
    t_dummy(8'h04, 3'd3, {8'h00, 1'b1, 8'hA5, 8'h3C, 8'h81, 31'h0});
    t_dummy(8'h09, 3'd4, {8'h00, 40'hD3_5E_01_FF_80, 16'h0});
    t_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule